// File: doc/BRIEF.md
# Packed Lane Shuffle and Unpack Unit

This block rearranges the 32-bit lanes of two 128-bit operands, called A and B, each holding four lanes. It moves bits and nothing else: no lane is read as a number, so every pattern, including NaN encodings and sign bits, reaches the output unchanged.

The unit has three modes:

- **Shuffle mode.** A control byte picks, for each destination lane, one source lane. The two lower destination lanes may pick only from A, and the two upper lanes may pick only from B. When the same value is given on both operands, any arrangement of its four lanes can be built.
- **Unpack-low mode.** The lower halves of A and B are interleaved lane by lane.
- **Unpack-high mode.** The upper halves of A and B are interleaved lane by lane.

A request is presented with an input strobe. The result is captured in a register on the next clock edge and is flagged by an output strobe for one cycle. The result holds its value until the next accepted request.

Top module: `pls_unit`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `out_valid` is 0 and `result` is all zeros.
- R2: With `mode[1]`=0 (shuffle), destination lane k for k=0,1 equals lane `ctrl[2k+1:2k]` of `src_a`. Lane n occupies bits [32n+31:32n].
- R3: With `mode[1]`=0, destination lane k for k=2,3 equals lane `ctrl[2k+1:2k]` of `src_b`. Control bits 7:6 belong to lane 3.
- R4: When `src_a` equals `src_b` in shuffle mode, each control byte produces the arrangement of that operand's lanes that it encodes, so every destination lane can reach every source lane.
- R5: `mode`=2'b10 (unpack-low) gives lanes 0..3 = A[0], B[0], A[1], B[1].
- R6: `mode`=2'b11 (unpack-high) gives lanes 0..3 = A[2], B[2], A[3], B[3].
- R7: In both unpack modes `ctrl` has no effect. In unpack-high the lower two lanes of both operands have no effect, and in unpack-low the upper two lanes of both operands have no effect.
- R8: Lane bits are copied exactly, including NaN payloads, infinities and sign bits.
- R9: A request taken with `in_valid`=1 at a rising edge appears on `result` with `out_valid`=1 right after that edge. Back-to-back requests are each delivered one cycle later.
- R10: With `in_valid`=0 at a rising edge, `out_valid` is 0 after that edge and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Bit 1: 0 = shuffle, 1 = unpack. Bit 0 picks the high half when unpacking |
| ctrl | input | 8 | Shuffle control, two bits per destination lane |
| src_a | input | 128 | First operand, four 32-bit lanes |
| src_b | input | 128 | Second operand, four 32-bit lanes |
| out_valid | output | 1 | Result strobe |
| result | output | 128 | Rearranged lanes |

## Verification
Every result is due exactly one rising edge after the request edge. The `out_valid` flag rises at that same edge and falls at the following edge unless another request arrives.

The bench drives inputs on falling edges. It compares `result` and `out_valid` on the next falling edge, half a cycle after the capture. On the falling edge after that it checks that `out_valid` has dropped and that `result` has held its value.

The streaming test checks each result on the same falling edge at which the next request is driven, which confirms the one-cycle spacing.

// File: rtl/pls_pkg.sv
package pls_pkg;

  typedef enum logic [1:0] {
    PLS_SHUF     = 2'b00,
    PLS_SHUF_ALT = 2'b01,
    PLS_UNPK_LO  = 2'b10,
    PLS_UNPK_HI  = 2'b11
  } pls_mode_e;

  function automatic logic mode_is_unpack(pls_mode_e m);
    return m[1];
  endfunction

  function automatic logic mode_takes_high(pls_mode_e m);
    return m[0];
  endfunction

  // Source lane index used by unpack for destination lane dst.
  function automatic int unpack_src_lane(int dst, int lanes, logic high);
    return (high ? lanes / 2 : 0) + dst / 2;
  endfunction

  // Odd destination lanes take the second operand when unpacking.
  function automatic logic unpack_uses_b(int dst);
    return (dst % 2) == 1;
  endfunction

endpackage

// File: rtl/pls_lane_route.sv
module pls_lane_route
  import pls_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  parameter int DST    = 0,
  localparam int SEL_W = $clog2(LANES),
  localparam int VEC_W = LANES * LANE_W
) (
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  input  logic [SEL_W-1:0]  sel,
  input  pls_mode_e         mode,
  output logic [LANE_W-1:0] lane_out
);

  localparam bit UPPER = (DST >= LANES / 2);
  localparam int LO_IX = unpack_src_lane(DST, LANES, 1'b0);
  localparam int HI_IX = unpack_src_lane(DST, LANES, 1'b1);
  localparam bit USE_B = unpack_uses_b(DST);

  logic [LANE_W-1:0] a_lane [LANES];
  logic [LANE_W-1:0] b_lane [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_split
    assign a_lane[i] = src_a[i*LANE_W +: LANE_W];
    assign b_lane[i] = src_b[i*LANE_W +: LANE_W];
  end

  logic [LANE_W-1:0] shuf_pick;
  logic [LANE_W-1:0] unpk_lo_pick;
  logic [LANE_W-1:0] unpk_hi_pick;

  // Shuffle: lower destination lanes draw from A, upper lanes from B.
  if (UPPER) begin : g_upper
    assign shuf_pick = b_lane[sel];
  end else begin : g_lower
    assign shuf_pick = a_lane[sel];
  end

  // Unpack: fixed interleave, even lanes from A and odd lanes from B.
  if (USE_B) begin : g_from_b
    assign unpk_lo_pick = b_lane[LO_IX];
    assign unpk_hi_pick = b_lane[HI_IX];
  end else begin : g_from_a
    assign unpk_lo_pick = a_lane[LO_IX];
    assign unpk_hi_pick = a_lane[HI_IX];
  end

  always_comb begin
    if (!mode_is_unpack(mode))
      lane_out = shuf_pick;
    else if (mode_takes_high(mode))
      lane_out = unpk_hi_pick;
    else
      lane_out = unpk_lo_pick;
  end

endmodule

// File: rtl/pls_out_reg.sv
module pls_out_reg #(
  parameter int WIDTH = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [WIDTH-1:0] d,
  output logic             q_valid,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else begin
      q_valid <= load;
      if (load) q <= d;
    end
  end

  // R10: an idle cycle leaves the stored result untouched.
  assert_hold_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (!q_valid && $stable(q)));

  // R9: an accepted request is flagged on the following cycle.
  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q_valid);

endmodule

// File: rtl/pls_unit.sv
module pls_unit
  import pls_pkg::*;
#(
  parameter int LANE_W = 32,
  parameter int LANES  = 4,
  localparam int SEL_W  = $clog2(LANES),
  localparam int VEC_W  = LANES * LANE_W,
  localparam int CTRL_W = LANES * SEL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic [CTRL_W-1:0] ctrl,
  input  logic [VEC_W-1:0]  src_a,
  input  logic [VEC_W-1:0]  src_b,
  output logic              out_valid,
  output logic [VEC_W-1:0]  result
);

  pls_mode_e        mode_e;
  logic [VEC_W-1:0] next_result;
  logic             load_evt;
  logic             shuf_evt;
  logic             unpk_hi_evt;
  logic             unpk_lo_evt;

  assign mode_e      = pls_mode_e'(mode);
  assign load_evt    = in_valid;
  assign shuf_evt    = in_valid && !mode_is_unpack(mode_e);
  assign unpk_hi_evt = in_valid &&  mode_is_unpack(mode_e) &&  mode_takes_high(mode_e);
  assign unpk_lo_evt = in_valid &&  mode_is_unpack(mode_e) && !mode_takes_high(mode_e);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    pls_lane_route #(
      .LANE_W (LANE_W),
      .LANES  (LANES),
      .DST    (k)
    ) u_route (
      .src_a    (src_a),
      .src_b    (src_b),
      .sel      (ctrl[k*SEL_W +: SEL_W]),
      .mode     (mode_e),
      .lane_out (next_result[k*LANE_W +: LANE_W])
    );
  end

  pls_out_reg #(.WIDTH(VEC_W)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load_evt),
    .d       (next_result),
    .q_valid (out_valid),
    .q       (result)
  );

  // R2: lane 0 of a shuffle comes from the A lane named by ctrl[1:0].
  assert_shuf_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_evt |=> result[0 +: LANE_W] ==
                 $past(src_a[ctrl[SEL_W-1:0]*LANE_W +: LANE_W]));

  // R3: the top lane of a shuffle comes from the B lane named by the top field.
  assert_shuf_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    shuf_evt |=> result[(LANES-1)*LANE_W +: LANE_W] ==
                 $past(src_b[ctrl[CTRL_W-1 -: SEL_W]*LANE_W +: LANE_W]));

  // R6: unpack-high starts with A and B lanes from the upper half.
  assert_unpack_hi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    unpk_hi_evt |=> (result[0 +: LANE_W] == $past(src_a[(LANES/2)*LANE_W +: LANE_W]) &&
                     result[LANE_W +: LANE_W] == $past(src_b[(LANES/2)*LANE_W +: LANE_W])));

  // R5: unpack-low starts with the bottom lanes of A and B.
  assert_unpack_lo_R5: assert property (@(posedge clk) disable iff (!rst_n)
    unpk_lo_evt |=> (result[0 +: LANE_W] == $past(src_a[0 +: LANE_W]) &&
                     result[LANE_W +: LANE_W] == $past(src_b[0 +: LANE_W])));

endmodule

// File: tb/pls_unit_test.sv
module pls_unit_test;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic [7:0]   ctrl = 8'h00;
  logic [127:0] src_a = '0;
  logic [127:0] src_b = '0;
  logic         out_valid;
  logic [127:0] result;

  int nvec = 0;
  int nbad = 0;

  always #4 clk = ~clk;

  pls_unit uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .ctrl(ctrl),
    .src_a(src_a), .src_b(src_b), .out_valid(out_valid), .result(result)
  );

  function automatic logic [127:0] model(logic [127:0] a, logic [127:0] b,
                                         logic [7:0] c, logic [1:0] m);
    logic [127:0] r;
    logic [127:0] sh;
    r = '0;
    if (!m[1]) begin
      for (int k = 0; k < 4; k++) begin
        sh = ((k < 2) ? a : b) >> (32 * c[2*k +: 2]);
        r[32*k +: 32] = sh[31:0];
      end
    end else if (m[0]) begin
      r = {b[127:96], a[127:96], b[95:64], a[95:64]};
    end else begin
      r = {b[63:32], a[63:32], b[31:0], a[31:0]};
    end
    return r;
  endfunction

  task automatic chk(string tag, logic [127:0] got, logic [127:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  // One request, then a check half a cycle after capture and an idle-hold check.
  task automatic run_one(string tag, logic [127:0] a, logic [127:0] b,
                         logic [7:0] c, logic [1:0] m);
    logic [127:0] exp;
    exp = model(a, b, c, m);
    @(negedge clk);
    src_a = a; src_b = b; ctrl = c; mode = m; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(tag, result, exp);
    chk("R9 out_valid", {127'd0, out_valid}, 128'd1);
    @(negedge clk);
    chk("R10 out_valid low", {127'd0, out_valid}, 128'd0);
    chk("R10 hold", result, exp);
  endtask

  task automatic t_reset;
    chk("R1 reset result", result, '0);
    chk("R1 reset valid", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset result", result, '0);
    chk("R1 after reset valid", {127'd0, out_valid}, 128'd0);
  endtask

  task automatic t_shuffle;
    logic [127:0] a, b;
    logic [7:0] cs [5] = '{8'h00, 8'hE4, 8'h1B, 8'hFF, 8'h4E};
    a = {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
    b = {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000};
    foreach (cs[i]) begin
      run_one("R2 R3 shuffle", a, b, cs[i], 2'b00);
    end
    run_one("R3 shuffle alt mode", a, b, 8'h93, 2'b01);
  endtask

  task automatic t_same_source;
    logic [127:0] a;
    a = {32'h3333_3333, 32'h2222_2222, 32'h1111_1111, 32'h0000_0000};
    run_one("R4 reverse", a, a, 8'h1B, 2'b00);
    run_one("R4 all lane2", a, a, 8'hAA, 2'b00);
    run_one("R4 mixed", a, a, 8'h2D, 2'b00);
  endtask

  task automatic t_unpack;
    logic [127:0] a, b, a2, b2, exp;
    a  = {32'hA3A3_0003, 32'hA2A2_0002, 32'hA1A1_0001, 32'hA0A0_0000};
    b  = {32'hB3B3_0003, 32'hB2B2_0002, 32'hB1B1_0001, 32'hB0B0_0000};
    run_one("R5 unpack low", a, b, 8'h00, 2'b10);
    run_one("R6 unpack high", a, b, 8'h00, 2'b11);
    // R7: a different ctrl and different ignored halves give the same result.
    a2 = {a[127:64], 64'hDEAD_BEEF_0BAD_F00D};
    b2 = {b[127:64], 64'hFEED_FACE_CAFE_D00D};
    exp = {b[127:96], a[127:96], b[95:64], a[95:64]};
    run_one("R7 unpack high ignores low", a2, b2, 8'h5A, 2'b11);
    chk("R7 unpack high fixed", result, exp);
    a2 = {64'h1234_5678_9ABC_DEF0, a[63:0]};
    b2 = {64'h0FED_CBA9_8765_4321, b[63:0]};
    exp = {b[63:32], a[63:32], b[31:0], a[31:0]};
    run_one("R7 unpack low ignores high", a2, b2, 8'hC3, 2'b10);
    chk("R7 unpack low fixed", result, exp);
  endtask

  task automatic t_nan;
    logic [127:0] a, b;
    a = {32'h7FC0_0001, 32'hFF80_0000, 32'h8000_0000, 32'h7F80_0001};
    b = {32'hFFFF_FFFF, 32'h7FBF_FFFF, 32'hFFC0_1234, 32'h0000_0001};
    run_one("R8 nan shuffle", a, b, 8'h72, 2'b00);
    run_one("R8 nan unpack", a, b, 8'h00, 2'b11);
  endtask

  task automatic t_stream;
    logic [127:0] a1, b1, a2, b2;
    a1 = {4{32'h0101_0101}} + 128'h3;
    b1 = {4{32'h0202_0202}} + 128'h5;
    a2 = {32'hC3, 32'hC2, 32'hC1, 32'hC0};
    b2 = {32'hD3, 32'hD2, 32'hD1, 32'hD0};
    @(negedge clk);
    chk("R9 idle before stream", {127'd0, out_valid}, 128'd0);
    src_a = a1; src_b = b1; ctrl = 8'h39; mode = 2'b00; in_valid = 1'b1;
    chk("R9 not early", {127'd0, out_valid}, 128'd0);
    @(negedge clk);
    chk("R9 stream first", result, model(a1, b1, 8'h39, 2'b00));
    src_a = a2; src_b = b2; mode = 2'b10;
    @(negedge clk);
    chk("R9 stream second", result, model(a2, b2, 8'h39, 2'b10));
    chk("R9 stream valid", {127'd0, out_valid}, 128'd1);
    in_valid = 1'b0;
    @(negedge clk);
    chk("R10 after stream", {127'd0, out_valid}, 128'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    #1;
    t_reset();
    t_shuffle();
    t_same_source();
    t_unpack();
    t_nan();
    t_stream();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule